// File: doc/BRIEF.md
# Programming-Status Read Path

This block is the read side of a byte-wide, page-programmed non-volatile memory model. When no internal programming cycle is running, it passes the stored byte from the array onto the data output. This happens only while the active-low chip select and output strobe are both asserted and the active-low write strobe is released. In every other case the output is left undriven. The output is modelled as a drive-enable flag plus a data word that reads all zeros whenever it is not driven.

While the write controller reports a programming cycle in progress, every read becomes a status read and returns no array content. The poll bit carries the inverse of the same bit of the most recently written byte. The toggle bit changes value on each new read. The remaining bits repeat the last written byte. A host can use either of the two flags to detect the end of programming. The block does not know why the write controller went busy, so a cycle started by a write that protection rejected reads back the same way. When busy falls, reads return true stored data and the toggle bit stops moving. The toggle state clears whenever a new programming cycle starts.

Control pins pass through `IN_STAGES` registers and the result through an optional output register. With the defaults, the output reflects the control pins two clock edges after they change.

Top module: `eep_status_read`

## Requirements
- R1: `rd_drive` is 1 exactly when, two clock edges earlier, `ce_n`=0, `oe_n`=0 and `we_n`=1 were sampled; while `rd_drive` is 0, `rd_data` is all zeros.
- R2: With `busy`=0, a driven read returns `array_data` unchanged on all 8 bits.
- R3: With `busy`=1, bit 7 of a driven read is the complement of bit 7 of `last_byte`.
- R4: With `busy`=1, bits 5 to 0 of a driven read equal bits 5 to 0 of `last_byte`.
- R5: With `busy`=1, bit 6 inverts on every new read; the first read after `prog_start` returns 1.
- R6: A new read begins when the read condition of R1 goes from false to true; holding the read condition does not change bit 6.
- R7: A `prog_start` pulse clears the toggle state, so the next read returns bit 6 = 1 whatever the number of earlier reads.
- R8: Once `busy` is 0, every read returns true data on all bits and bit 6 no longer alternates between reads.
- R9: While `busy`=1, reads return status and never `array_data`, including when the array content was not changed by the write that started the cycle.
- R10: A read started by `ce_n` falling while `oe_n` is already low counts as a new read for bit 6, in the same way as one started by `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output strobe |
| we_n | input | 1 | Active-low write strobe |
| busy | input | 1 | Programming cycle in progress, from the write controller |
| prog_start | input | 1 | One-cycle pulse when a programming cycle begins |
| last_byte | input | 8 | Most recently written byte, from the write controller |
| array_data | input | 8 | Stored byte at the current address, from the array |
| rd_data | output | 8 | Read data, zero when not driven |
| rd_drive | output | 1 | Output drive enable; 0 means high impedance |

## Verification
Changes on the control pins reach `rd_drive` and `rd_data` two rising edges later. The toggle flip-flop is updated on the same edge at which the output register captures the new read. The bench therefore changes the strobes on a falling edge and samples the outputs on the second falling edge after that. Before each read ends, the bench waits three falling edges with the strobes released, so that the next read is seen as a new one. `busy`, `last_byte` and `array_data` are set at least one full cycle before the strobes move, so the captured value never depends on an input changing at the sampling edge.

// File: rtl/eep_rd_pkg.sv
package eep_rd_pkg;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
   } rd_ctl_t;

   localparam rd_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

   function automatic logic ctl_is_read(input rd_ctl_t c);
      return (!c.ce_n) && (!c.oe_n) && c.we_n;
   endfunction

endpackage

// File: rtl/eep_rd_ctl_pipe.sv
module eep_rd_ctl_pipe
   import eep_rd_pkg::*;
#(
   parameter int IN_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic rd_act,
   output logic rd_start
);

   rd_ctl_t stg_q [IN_STAGES];
   logic    act_prev_q;

   generate
      for (genvar s = 0; s < IN_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= CTL_IDLE;
               else        stg_q[s] <= '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= CTL_IDLE;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign rd_act = ctl_is_read(stg_q[IN_STAGES-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_prev_q <= 1'b0;
      else        act_prev_q <= rd_act;
   end

   assign rd_start = rd_act && !act_prev_q;

endmodule

// File: rtl/eep_rd_toggle.sv
module eep_rd_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic prog_start,
   input  logic busy,
   input  logic rd_start,
   output logic tgl_q,
   output logic tgl_nxt
);

   logic base;

   always_comb begin
      base    = prog_start ? 1'b0 : tgl_q;
      tgl_nxt = base ^ (busy && rd_start);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgl_q <= 1'b0;
      else        tgl_q <= tgl_nxt;
   end

endmodule

// File: rtl/eep_rd_status_mux.sv
module eep_rd_status_mux #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int TGL_BIT  = 6
) (
   input  logic              busy,
   input  logic              tgl,
   input  logic [DATA_W-1:0] last_byte,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] mux_data
);

   logic [DATA_W-1:0] status;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (b == POLL_BIT) begin : g_poll
            assign status[b] = ~last_byte[b];
         end else if (b == TGL_BIT) begin : g_tgl
            assign status[b] = tgl;
         end else begin : g_echo
            assign status[b] = last_byte[b];
         end
      end
   endgenerate

   assign mux_data = busy ? status : array_data;

endmodule

// File: rtl/eep_rd_out_stage.sv
module eep_rd_out_stage #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drive_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              drive_out,
   output logic [DATA_W-1:0] data_out
);

   logic [DATA_W-1:0] gated;

   assign gated = drive_in ? data_in : '0;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               drive_out <= 1'b0;
               data_out  <= '0;
            end else begin
               drive_out <= drive_in;
               data_out  <= gated;
            end
         end
      end else begin : g_comb
         assign drive_out = drive_in;
         assign data_out  = gated;
      end
   endgenerate

endmodule

// File: rtl/eep_status_read.sv
module eep_status_read #(
   parameter int DATA_W    = 8,
   parameter int POLL_BIT  = 7,
   parameter int TGL_BIT   = 6,
   parameter int IN_STAGES = 1,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              busy,
   input  logic              prog_start,
   input  logic [DATA_W-1:0] last_byte,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive
);

   localparam int LAT = IN_STAGES + (OUT_REG ? 1 : 0);

   generate
      if (POLL_BIT >= DATA_W || TGL_BIT >= DATA_W) begin : g_bad_pos
         $error("status bit position outside data width");
      end
      if (POLL_BIT == TGL_BIT) begin : g_bad_same
         $error("poll and toggle bits must differ");
      end
      if (IN_STAGES < 1) begin : g_bad_stages
         $error("at least one input stage is needed");
      end
   endgenerate

   logic              rd_act;
   logic              rd_start;
   logic              tgl_state;
   logic              tgl_nxt;
   logic [DATA_W-1:0] mux_data;

   eep_rd_ctl_pipe #(.IN_STAGES(IN_STAGES)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .rd_act   (rd_act),
      .rd_start (rd_start)
   );

   eep_rd_toggle u_tgl (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog_start (prog_start),
      .busy       (busy),
      .rd_start   (rd_start),
      .tgl_q      (tgl_state),
      .tgl_nxt    (tgl_nxt)
   );

   eep_rd_status_mux #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT),
      .TGL_BIT  (TGL_BIT)
   ) u_mux (
      .busy       (busy),
      .tgl        (tgl_nxt),
      .last_byte  (last_byte),
      .array_data (array_data),
      .mux_data   (mux_data)
   );

   eep_rd_out_stage #(
      .DATA_W  (DATA_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .drive_in  (rd_act),
      .data_in   (mux_data),
      .drive_out (rd_drive),
      .data_out  (rd_data)
   );

endmodule

// File: rtl/eep_status_read_chk.sv
module eep_status_read_chk #(
   parameter int DATA_W   = 8,
   parameter int POLL_BIT = 7,
   parameter int LAT      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              busy,
   input logic              prog_start,
   input logic [DATA_W-1:0] last_byte,
   input logic [DATA_W-1:0] array_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_drive,
   input logic              tgl_state,
   input logic              rd_start
);

   logic [3:0] age_q;
   logic       pin_read;
   logic       aged;

   assign pin_read = !ce_n && !oe_n && we_n;
   assign aged     = (age_q >= 4'(LAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     age_q <= '0;
      else if (!aged) age_q <= age_q + 4'd1;
   end

   // R1
   drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aged |-> (rd_drive == $past(pin_read, LAT)));

   // R1
   undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_drive |-> (rd_data == '0));

   // R2
   idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_drive && !busy && $stable(busy) && $stable(array_data))
      |-> (rd_data == array_data));

   // R3
   poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_drive && busy && $stable(busy) && $stable(last_byte))
      |-> (rd_data[POLL_BIT] == !last_byte[POLL_BIT]));

   // R5
   tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_start && !prog_start) |=> (tgl_state != $past(tgl_state)));

   // R7
   tgl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_start && !rd_start) |=> !tgl_state);

   // R8
   tgl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !prog_start) |=> $stable(tgl_state));

endmodule

bind eep_status_read eep_status_read_chk #(
   .DATA_W   (DATA_W),
   .POLL_BIT (POLL_BIT),
   .LAT      (LAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .oe_n       (oe_n),
   .we_n       (we_n),
   .busy       (busy),
   .prog_start (prog_start),
   .last_byte  (last_byte),
   .array_data (array_data),
   .rd_data    (rd_data),
   .rd_drive   (rd_drive),
   .tgl_state  (tgl_state),
   .rd_start   (rd_start)
);

// File: tb/test_eep_status_read.sv
module test_eep_status_read;

   localparam int LAT = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1;
   logic       oe_n = 1'b1;
   logic       we_n = 1'b1;
   logic       busy = 1'b0;
   logic       prog_start = 1'b0;
   logic [7:0] last_byte = 8'h00;
   logic [7:0] array_data = 8'h00;
   logic [7:0] rd_data;
   logic       rd_drive;

   int nchk = 0;
   int nerr = 0;

   always #10 clk = ~clk;

   eep_status_read i_eep_status_read (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .oe_n       (oe_n),
      .we_n       (we_n),
      .busy       (busy),
      .prog_start (prog_start),
      .last_byte  (last_byte),
      .array_data (array_data),
      .rd_data    (rd_data),
      .rd_drive   (rd_drive)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic start_read(output logic [7:0] d, output logic drv);
      @(negedge clk);
      ce_n = 1'b0;
      oe_n = 1'b0;
      repeat (LAT) @(negedge clk);
      d   = rd_data;
      drv = rd_drive;
   endtask

   task automatic end_read();
      ce_n = 1'b1;
      oe_n = 1'b1;
      we_n = 1'b1;
      repeat (LAT + 1) @(negedge clk);
   endtask

   task automatic start_prog(input logic [7:0] b);
      @(negedge clk);
      last_byte  = b;
      busy       = 1'b1;
      prog_start = 1'b1;
      @(negedge clk);
      prog_start = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset drive", {7'd0, rd_drive}, 8'h00);
      chk("R1 reset data", rd_data, 8'h00);
   endtask

   task automatic t_gate();
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
      repeat (LAT) @(negedge clk);
      chk("R1 write strobe low blocks drive", {7'd0, rd_drive}, 8'h00);
      chk("R1 undriven data zero", rd_data, 8'h00);
      end_read();
      oe_n = 1'b0;
      repeat (LAT + 1) @(negedge clk);
      chk("R1 select high blocks drive", {7'd0, rd_drive}, 8'h00);
      end_read();
   endtask

   task automatic t_idle();
      logic [7:0] d;
      logic       v;
      array_data = 8'hA5;
      start_read(d, v);
      chk("R1 read drives", {7'd0, v}, 8'h01);
      chk("R2 idle data A5", d, 8'hA5);
      end_read();
      array_data = 8'h3C;
      start_read(d, v);
      chk("R2 idle data 3C", d, 8'h3C);
      end_read();
   endtask

   task automatic t_poll();
      logic [7:0] d;
      logic       v;
      array_data = 8'h00;
      start_prog(8'h9A);
      start_read(d, v);
      chk("R3 poll bit inverted", {7'd0, d[7]}, 8'h00);
      chk("R4 low bits echo", {2'b00, d[5:0]}, 8'h1A);
      chk("R9 status not array", d, 8'h5A);
      end_read();
      start_prog(8'h25);
      start_read(d, v);
      chk("R3 R4 status for 25", d, 8'hE5);
      end_read();
      busy = 1'b0;
   endtask

   task automatic t_toggle();
      logic [7:0] d;
      logic       v;
      start_prog(8'h00);
      for (int i = 0; i < 4; i++) begin
         start_read(d, v);
         chk("R5 toggle sequence", d, (i % 2 == 0) ? 8'hC0 : 8'h80);
         end_read();
      end
      busy = 1'b0;
   endtask

   task automatic t_hold();
      logic [7:0] d;
      logic       v;
      start_prog(8'h00);
      start_read(d, v);
      chk("R6 first read", {7'd0, d[6]}, 8'h01);
      repeat (5) @(negedge clk);
      chk("R6 held read keeps bit6", {7'd0, rd_data[6]}, 8'h01);
      end_read();
      start_read(d, v);
      chk("R6 new read flips", {7'd0, d[6]}, 8'h00);
      end_read();
      busy = 1'b0;
   endtask

   task automatic t_ce_start();
      logic [7:0] d;
      logic       v;
      start_prog(8'h00);
      start_read(d, v);
      chk("R10 first read", {7'd0, d[6]}, 8'h01);
      end_read();
      oe_n = 1'b0;
      repeat (LAT + 1) @(negedge clk);
      chk("R10 strobe alone not driven", {7'd0, rd_drive}, 8'h00);
      ce_n = 1'b0;
      repeat (LAT) @(negedge clk);
      chk("R10 select-started read driven", {7'd0, rd_drive}, 8'h01);
      chk("R10 select-started read flips", {7'd0, rd_data[6]}, 8'h00);
      end_read();
      busy = 1'b0;
   endtask

   task automatic t_clear();
      logic [7:0] d;
      logic       v;
      start_prog(8'h00);
      start_read(d, v);
      end_read();
      start_prog(8'h00);
      start_read(d, v);
      chk("R7 new cycle restarts bit6 at 1", {7'd0, d[6]}, 8'h01);
      end_read();
      busy = 1'b0;
   endtask

   task automatic t_done();
      logic [7:0] d;
      logic       v;
      array_data = 8'hC3;
      start_prog(8'h55);
      start_read(d, v);
      chk("R9 busy hides array", d, 8'hD5);
      end_read();
      busy = 1'b0;
      @(negedge clk);
      start_read(d, v);
      chk("R8 true data after busy", d, 8'hC3);
      end_read();
      start_read(d, v);
      chk("R8 bit6 steady next read", d, 8'hC3);
      end_read();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_gate();
      t_idle();
      t_poll();
      t_toggle();
      t_hold();
      t_ce_start();
      t_clear();
      t_done();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule